// File: doc/BRIEF.md
# DTMF Tone-Pair Period-Counting Detector

This block takes the two limited square waves that come out of a telephone receiver's low-band and high-band filters and works out which keypad tone pair is present. It times each signal by counting system-clock cycles between successive rising edges. It compares every measured period with four acceptance windows per group, one window for each nominal tone. A group reports a tone only after several back-to-back periods land in the same window, which keeps short voice fragments from imitating a key.

For each group the block reports a 2-bit tone index and a valid flag. An early-steering flag is high while both groups hold a valid tone at the same time. Downstream timing logic uses that flag to qualify a key press. An inhibit input removes the highest column tone from consideration. A power-down input freezes detection and clears all detection state.

All period windows are elaboration-time constants. They are computed from the clock frequency parameter (3.579545 MHz by default) and a tolerance in tenths of a percent.

Top module: `dtmf_period_detector`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge) both valid flags, both indices and `early_steer` are 0.
- R2: A steady row tone reports `row_valid`=1 with `row_idx` 0 for 697 Hz, 1 for 770 Hz, 2 for 852 Hz and 3 for 941 Hz.
- R3: A steady column tone reports `col_valid`=1 with `col_idx` 0 for 1209 Hz, 1 for 1336 Hz, 2 for 1477 Hz and 3 for 1633 Hz.
- R4: A period is in a window when it lies within ±TOL_PERMILLE/1000 (default 2.5%) of CLK_HZ/f clock cycles. A tone deviating by 1.5% plus 2 Hz is therefore accepted, and a tone deviating by 3.5% is never reported.
- R5: A group becomes valid only when CONFIRM (default 4) consecutive measured periods fall in the same window. The flag and index update on the third clock edge after the first edge that samples the rising input ending the last of those periods.
- R6: Valid drops when a measured period is outside every window or lands in a different window. A new tone then needs CONFIRM fresh periods. While valid stays high, the index does not change.
- R7: If no rising edge arrives, valid drops on the (TIMEOUT_CYC+2)-th clock edge after the first edge that sampled the last rising input high.
- R8: `early_steer` is high exactly when `row_valid` and `col_valid` are both high. It falls in the same cycle as either flag.
- R9: While `inhibit_top` is high, a column period in the 1633 Hz window counts as out of window. A 1633 Hz column already reported falls one clock edge after `inhibit_top` is sampled high. Rows are unaffected.
- R10: While `power_down` is high, each clock edge clears both valid flags, both indices and all measurement state, and no tone can become valid.
- R11: After valid drops for any reason other than reset or power-down, the index keeps its last reported value.
- R12: The first rising edge after reset, power-down or a silence timeout only starts timing. It does not complete a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| row_sq | input | 1 | Limited low-band signal (asynchronous) |
| col_sq | input | 1 | Limited high-band signal (asynchronous) |
| inhibit_top | input | 1 | Excludes the 1633 Hz column tone while high |
| power_down | input | 1 | Halts detection and clears state while high |
| row_valid | output | 1 | A row tone is confirmed |
| row_idx | output | 2 | Index of the confirmed or last row tone |
| col_valid | output | 1 | A column tone is confirmed |
| col_idx | output | 2 | Index of the confirmed or last column tone |
| early_steer | output | 1 | Both groups hold a valid tone |

## Verification
The bench drives square waves at the nominal tones, at the edges of the accepted tolerance and beyond the rejection limit, and a behavioural model predicts every output on every clock.

- A design that counted the first edge as a period, or confirmed after too few periods, would raise valid one period early.
- A design that checked windows too loosely would report the 3.5%-deviated row.
- Scenarios that switch column tones, stop one band, and toggle inhibit and power-down during a confirmed tone target further faults:
  - keeping a stale index while valid;
  - missing the silence timeout;
  - still showing 1633 Hz under inhibit;
  - forgetting the last index after dropout.

// File: rtl/dtmf_pkg.sv
// Shared constants and elaboration-time helpers for the DTMF detector.
// Assumes tone frequencies are far below the clock so periods are large integers.
package dtmf_pkg;

    localparam int NUM_TONES = 4;
    localparam int IDX_W     = 2;

    typedef enum logic {
        GRP_ROW = 1'b0,
        GRP_COL = 1'b1
    } grp_e;

    // Nominal tone frequency in Hz for a group and index.
    function automatic int tone_hz(input grp_e grp, input int idx);
        int f;
        f = 0;
        if (grp == GRP_ROW) begin
            case (idx)
                0: f = 697;
                1: f = 770;
                2: f = 852;
                default: f = 941;
            endcase
        end else begin
            case (idx)
                0: f = 1209;
                1: f = 1336;
                2: f = 1477;
                default: f = 1633;
            endcase
        end
        return f;
    endfunction

    // Rounded number of clock cycles in one tone period.
    function automatic int nominal_period(input int clk_hz, input int f_hz);
        return (clk_hz + f_hz / 2) / f_hz;
    endfunction

    // Lower window bound in cycles, tolerance in tenths of a percent.
    function automatic int window_low(input int nom, input int tol_permille);
        return (nom * (1000 - tol_permille)) / 1000;
    endfunction

    // Upper window bound in cycles.
    function automatic int window_high(input int nom, input int tol_permille);
        return (nom * (1000 + tol_permille)) / 1000;
    endfunction

endpackage

// File: rtl/dtmf_edge_sync.sv
// Brings an asynchronous square wave into the clock domain and flags rising edges.
// Assumes STAGES >= 2; the edge flag is combinational from the last two flops.
module dtmf_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sq_in,
    output logic rise
);

    logic [STAGES:0] shreg;

    // Shift the input through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[STAGES-1:0], sq_in};
        end
    end

    assign rise = shreg[STAGES-1] & ~shreg[STAGES];

endmodule

// File: rtl/dtmf_period_meter.sv
// Counts clock cycles between rising edges and emits one period strobe per edge pair.
// The first edge after reset, halt or silence only arms the meter. A silence strobe
// fires once when TIMEOUT_CYC-1 cycles pass without an edge; the count then saturates.
module dtmf_period_meter #(
    parameter int CNT_W       = 13,
    parameter int TIMEOUT_CYC = 7000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic             rise,
    output logic [CNT_W-1:0] period,
    output logic             period_stb,
    output logic             silence_stb
);

    localparam logic [CNT_W-1:0] LIMIT    = CNT_W'(TIMEOUT_CYC);
    localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic             armed;

    // Measure edge-to-edge spacing and detect a missing signal.
    always_ff @(posedge clk) begin
        if (!rst_n || halt) begin
            cnt         <= '0;
            armed       <= 1'b0;
            period      <= '0;
            period_stb  <= 1'b0;
            silence_stb <= 1'b0;
        end else begin
            period_stb  <= 1'b0;
            silence_stb <= 1'b0;
            if (rise) begin
                if (armed) begin
                    period     <= cnt;
                    period_stb <= 1'b1;
                end
                cnt   <= ONE;
                armed <= 1'b1;
            end else begin
                if (cnt != LIMIT) begin
                    cnt <= cnt + ONE;
                end
                if (cnt == LIMIT_M1) begin
                    silence_stb <= 1'b1;
                    armed       <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/dtmf_tone_classifier.sv
// Matches measured periods against four tone windows and confirms a tone after
// CONFIRM consecutive hits in the same window. mask_top removes window 3.
// Assumes windows do not overlap, which holds for the tone plan at small tolerances.
module dtmf_tone_classifier #(
    parameter dtmf_pkg::grp_e GROUP        = dtmf_pkg::GRP_ROW,
    parameter int             CLK_HZ       = 3579545,
    parameter int             TOL_PERMILLE = 25,
    parameter int             CONFIRM      = 4,
    parameter int             CNT_W        = 13
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       halt,
    input  logic                       mask_top,
    input  logic [CNT_W-1:0]           period,
    input  logic                       period_stb,
    input  logic                       silence_stb,
    output logic                       tone_valid,
    output logic [dtmf_pkg::IDX_W-1:0] tone_idx
);

    localparam int N     = dtmf_pkg::NUM_TONES;
    localparam int IW    = dtmf_pkg::IDX_W;
    localparam int RUN_W = $clog2(CONFIRM + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(CONFIRM);
    localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);
    localparam logic [IW-1:0]    TOP_IDX = IW'(N - 1);

    logic [N-1:0]     in_win;
    logic [N-1:0]     win_ok;
    logic             hit;
    logic [IW-1:0]    hit_idx;
    logic [RUN_W-1:0] run;
    logic [RUN_W-1:0] run_next;
    logic [IW-1:0]    cand;

    // One comparator pair per tone window, bounds fixed at elaboration.
    for (genvar i = 0; i < N; i++) begin : g_win
        localparam int NOM = dtmf_pkg::nominal_period(CLK_HZ, dtmf_pkg::tone_hz(GROUP, i));
        localparam int LO  = dtmf_pkg::window_low(NOM, TOL_PERMILLE);
        localparam int HI  = dtmf_pkg::window_high(NOM, TOL_PERMILLE);
        assign in_win[i] = (int'(period) >= LO) && (int'(period) <= HI);
    end

    assign win_ok = in_win & ~{mask_top, {(N-1){1'b0}}};
    assign hit    = |win_ok;

    // Encode the matching window; windows are disjoint so at most one is set.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (win_ok[i]) begin
                hit_idx = IW'(i);
            end
        end
    end

    // Extend the run on a repeat hit in the same window, otherwise restart at one.
    always_comb begin
        if ((run != '0) && (hit_idx == cand)) begin
            run_next = (run == RUN_MAX) ? run : run + RUN_ONE;
        end else begin
            run_next = RUN_ONE;
        end
    end

    // Track consecutive hits and publish a confirmed tone.
    always_ff @(posedge clk) begin
        if (!rst_n || halt) begin
            run        <= '0;
            cand       <= '0;
            tone_valid <= 1'b0;
            tone_idx   <= '0;
        end else if (silence_stb) begin
            run        <= '0;
            tone_valid <= 1'b0;
        end else if (period_stb) begin
            if (!hit) begin
                run        <= '0;
                tone_valid <= 1'b0;
            end else begin
                run        <= run_next;
                cand       <= hit_idx;
                tone_valid <= (run_next == RUN_MAX);
                if (run_next == RUN_MAX) begin
                    tone_idx <= hit_idx;
                end
            end
        end else if (tone_valid && mask_top && (tone_idx == TOP_IDX)) begin
            tone_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/dtmf_tone_group.sv
// One frequency group: synchroniser, period meter and window classifier in series.
// Latency from the first clock edge sampling a rising input to a valid update is 3 edges.
module dtmf_tone_group #(
    parameter dtmf_pkg::grp_e GROUP        = dtmf_pkg::GRP_ROW,
    parameter int             CLK_HZ       = 3579545,
    parameter int             TOL_PERMILLE = 25,
    parameter int             CONFIRM      = 4,
    parameter int             TIMEOUT_CYC  = 7000,
    parameter int             CNT_W        = 13
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       halt,
    input  logic                       sq_in,
    input  logic                       mask_top,
    output logic                       tone_valid,
    output logic [dtmf_pkg::IDX_W-1:0] tone_idx
);

    logic             rise;
    logic [CNT_W-1:0] period;
    logic             period_stb;
    logic             silence_stb;

    dtmf_edge_sync #(
        .STAGES (2)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .sq_in (sq_in),
        .rise  (rise)
    );

    dtmf_period_meter #(
        .CNT_W       (CNT_W),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) i_meter (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt        (halt),
        .rise        (rise),
        .period      (period),
        .period_stb  (period_stb),
        .silence_stb (silence_stb)
    );

    dtmf_tone_classifier #(
        .GROUP        (GROUP),
        .CLK_HZ       (CLK_HZ),
        .TOL_PERMILLE (TOL_PERMILLE),
        .CONFIRM      (CONFIRM),
        .CNT_W        (CNT_W)
    ) i_class (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt        (halt),
        .mask_top    (mask_top),
        .period      (period),
        .period_stb  (period_stb),
        .silence_stb (silence_stb),
        .tone_valid  (tone_valid),
        .tone_idx    (tone_idx)
    );

endmodule

// File: rtl/dtmf_period_detector.sv
// DTMF tone-pair detector: one row group and one column group, plus the early
// steering flag. Inputs row_sq/col_sq are limited filter outputs, asynchronous to clk.
// TIMEOUT_CYC must exceed the slowest accepted row period.
module dtmf_period_detector #(
    parameter int CLK_HZ       = 3579545,
    parameter int TOL_PERMILLE = 25,
    parameter int CONFIRM      = 4,
    parameter int TIMEOUT_CYC  = 7000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       row_sq,
    input  logic       col_sq,
    input  logic       inhibit_top,
    input  logic       power_down,
    output logic       row_valid,
    output logic [1:0] row_idx,
    output logic       col_valid,
    output logic [1:0] col_idx,
    output logic       early_steer
);

    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

    dtmf_tone_group #(
        .GROUP        (dtmf_pkg::GRP_ROW),
        .CLK_HZ       (CLK_HZ),
        .TOL_PERMILLE (TOL_PERMILLE),
        .CONFIRM      (CONFIRM),
        .TIMEOUT_CYC  (TIMEOUT_CYC),
        .CNT_W        (CNT_W)
    ) i_row (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt       (power_down),
        .sq_in      (row_sq),
        .mask_top   (1'b0),
        .tone_valid (row_valid),
        .tone_idx   (row_idx)
    );

    dtmf_tone_group #(
        .GROUP        (dtmf_pkg::GRP_COL),
        .CLK_HZ       (CLK_HZ),
        .TOL_PERMILLE (TOL_PERMILLE),
        .CONFIRM      (CONFIRM),
        .TIMEOUT_CYC  (TIMEOUT_CYC),
        .CNT_W        (CNT_W)
    ) i_col (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt       (power_down),
        .sq_in      (col_sq),
        .mask_top   (inhibit_top),
        .tone_valid (col_valid),
        .tone_idx   (col_idx)
    );

    assign early_steer = row_valid & col_valid;

endmodule

// File: rtl/dtmf_period_detector_chk.sv
// Temporal checks on the detector's ports, attached by bind.
module dtmf_period_detector_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       inhibit_top,
    input logic       power_down,
    input logic       row_valid,
    input logic [1:0] row_idx,
    input logic       col_valid,
    input logic [1:0] col_idx,
    input logic       early_steer
);

    a_r10_pd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |=> (!row_valid && !col_valid && row_idx == 2'd0 && col_idx == 2'd0));

    a_r10_no_rise_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(row_valid) || $rose(col_valid)) |-> !$past(power_down));

    a_r9_inhibit_blocks_top: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inhibit_top) |-> !(col_valid && col_idx == 2'd3));

    a_r8_steer_falls: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(row_valid) || $fell(col_valid)) |-> !early_steer);

    a_r6_row_idx_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && $past(row_valid)) |-> $stable(row_idx));

    a_r6_col_idx_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && $past(col_valid)) |-> $stable(col_idx));

endmodule

bind dtmf_period_detector dtmf_period_detector_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .inhibit_top (inhibit_top),
    .power_down  (power_down),
    .row_valid   (row_valid),
    .row_idx     (row_idx),
    .col_valid   (col_valid),
    .col_idx     (col_idx),
    .early_steer (early_steer)
);

// File: tb/test_dtmf_period_detector.sv
// Bench: behavioural per-clock model plus scenario checks at chosen instants.
module test_dtmf_period_detector;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 357954;
    localparam int TOL        = 25;
    localparam int CONFIRM    = 4;
    localparam int TIMEOUT    = 700;
    localparam int ROW_F [4]  = '{697, 770, 852, 941};
    localparam int COL_F [4]  = '{1209, 1336, 1477, 1633};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       row_sq = 1'b0;
    logic       col_sq = 1'b0;
    logic       inhibit_top = 1'b0;
    logic       power_down = 1'b0;
    logic       row_valid;
    logic [1:0] row_idx;
    logic       col_valid;
    logic [1:0] col_idx;
    logic       early_steer;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 1'b0;
    bit  cmp_en = 1'b0;
    int  lo_per = 0;
    int  hi_per = 0;

    dtmf_period_detector #(
        .CLK_HZ       (CLK_HZ),
        .TOL_PERMILLE (TOL),
        .CONFIRM      (CONFIRM),
        .TIMEOUT_CYC  (TIMEOUT)
    ) i_dtmf_period_detector (
        .clk         (clk),
        .rst_n       (rst_n),
        .row_sq      (row_sq),
        .col_sq      (col_sq),
        .inhibit_top (inhibit_top),
        .power_down  (power_down),
        .row_valid   (row_valid),
        .row_idx     (row_idx),
        .col_valid   (col_valid),
        .col_idx     (col_idx),
        .early_steer (early_steer)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int per_of(input real f);
        return int'(real'(CLK_HZ) / f);
    endfunction

    // Model window test from R4: within 2.5% of the ideal period; R9 mask on top column.
    function automatic int classify(input int g, input int p, input bit inh);
        int k_hit;
        k_hit = -1;
        for (int k = 0; k < 4; k++) begin
            real nom;
            nom = real'(CLK_HZ) / real'((g == 0) ? ROW_F[k] : COL_F[k]);
            if ((real'(p) >= nom * 0.975) && (real'(p) <= nom * 1.025)) k_hit = k;
        end
        if (g == 1 && inh && k_hit == 3) k_hit = -1;
        return k_hit;
    endfunction

    // Square-wave generators, driven away from the active edge.
    initial begin
        int ph_lo, ph_hi, prev_lo, prev_hi;
        ph_lo = 0; ph_hi = 0; prev_lo = 0; prev_hi = 0;
        forever begin
            @(negedge clk);
            if (lo_per != prev_lo) begin ph_lo = 0; prev_lo = lo_per; end
            if (hi_per != prev_hi) begin ph_hi = 0; prev_hi = hi_per; end
            if (lo_per == 0) row_sq = 1'b0;
            else begin
                row_sq = (ph_lo < lo_per / 2);
                ph_lo = (ph_lo + 1 >= lo_per) ? 0 : ph_lo + 1;
            end
            if (hi_per == 0) col_sq = 1'b0;
            else begin
                col_sq = (ph_hi < hi_per / 2);
                ph_hi = (ph_hi + 1 >= hi_per) ? 0 : ph_hi + 1;
            end
        end
    end

    // Reference model state, one entry per group (0 row, 1 column).
    int hist [2][3];
    bit armed [2];
    int since [2];
    bit pend_s [2];
    bit pend_t [2];
    int pend_p [2];
    int run [2];
    int cand [2];
    bit mv [2];
    int mi [2];

    // Behavioural model: 2-cycle input sampling, period timing, run counting.
    always @(posedge clk) begin
        for (int g = 0; g < 2; g++) begin
            bit cur;
            bit r;
            int k;
            cur = (g == 0) ? row_sq : col_sq;
            if (!rst_n) begin
                hist[g][0] = 0; hist[g][1] = 0; hist[g][2] = 0;
                armed[g] = 0; since[g] = 0; pend_s[g] = 0; pend_t[g] = 0; pend_p[g] = 0;
                run[g] = 0; cand[g] = 0; mv[g] = 0; mi[g] = 0;
            end else begin
                r = (hist[g][1] == 1) && (hist[g][2] == 0);
                if (power_down) begin
                    armed[g] = 0; since[g] = 0; pend_s[g] = 0; pend_t[g] = 0;
                    run[g] = 0; cand[g] = 0; mv[g] = 0; mi[g] = 0;
                end else begin
                    if (pend_t[g]) begin
                        run[g] = 0; mv[g] = 0;
                    end else if (pend_s[g]) begin
                        k = classify(g, pend_p[g], inhibit_top);
                        if (k < 0) begin
                            run[g] = 0; mv[g] = 0;
                        end else begin
                            if (run[g] > 0 && k == cand[g]) begin
                                if (run[g] < CONFIRM) run[g]++;
                            end else begin
                                cand[g] = k; run[g] = 1;
                            end
                            mv[g] = (run[g] >= CONFIRM);
                            if (mv[g]) mi[g] = cand[g];
                        end
                    end else if (mv[g] && g == 1 && inhibit_top && mi[g] == 3) begin
                        mv[g] = 0;
                    end
                    pend_s[g] = 0; pend_t[g] = 0;
                    if (r) begin
                        if (armed[g]) begin pend_s[g] = 1; pend_p[g] = since[g]; end
                        since[g] = 1; armed[g] = 1;
                    end else begin
                        if (since[g] == TIMEOUT - 1) begin pend_t[g] = 1; armed[g] = 0; end
                        if (since[g] < TIMEOUT) since[g]++;
                    end
                end
                hist[g][2] = hist[g][1]; hist[g][1] = hist[g][0]; hist[g][0] = int'(cur);
            end
        end
    end

    // Per-clock comparison against the model (R5 timing, R11 index, R8 steering).
    always @(negedge clk) begin
        if (cmp_en) begin
            check(row_valid == mv[0], "R5 row_valid vs model", int'(row_valid), int'(mv[0]));
            check(col_valid == mv[1], "R5 col_valid vs model", int'(col_valid), int'(mv[1]));
            check(int'(row_idx) == mi[0], "R11 row_idx vs model", int'(row_idx), mi[0]);
            check(int'(col_idx) == mi[1], "R11 col_idx vs model", int'(col_idx), mi[1]);
            check(early_steer == (mv[0] && mv[1]), "R8 early_steer vs model",
                  int'(early_steer), int'(mv[0] && mv[1]));
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_tones(input int lp, input int hp);
        @(negedge clk);
        lo_per = lp;
        hi_per = hp;
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R5 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int p697, p941d, p1633d, p770r;
        p697   = per_of(697.0);
        p941d  = per_of(941.0 * 1.015 + 2.0);
        p1633d = per_of(1633.0 * 0.985 - 2.0);
        p770r  = per_of(770.0 * 1.035);

        // R1: reset state
        wait_cyc(5);
        check(!row_valid && !col_valid && !early_steer, "R1 flags in reset",
              int'({row_valid, col_valid, early_steer}), 0);
        check(row_idx == 2'd0 && col_idx == 2'd0, "R1 indices in reset",
              int'({row_idx, col_idx}), 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R12 and R2/R3: nominal 697 + 1209
        set_tones(p697, per_of(1209.0));
        wait_cyc(p697 * 3 + p697 / 2);
        check(!row_valid, "R12 first edge only arms", int'(row_valid), 0);
        wait_cyc(p697 * 3);
        check(row_valid && row_idx == 2'd0, "R2 row 697 -> 0", int'(row_idx), 0);
        check(col_valid && col_idx == 2'd0, "R3 col 1209 -> 0", int'(col_idx), 0);
        check(early_steer, "R8 steer with both valid", int'(early_steer), 1);

        // R4: deviation by 1.5% + 2 Hz accepted
        set_tones(p941d, p1633d);
        wait_cyc(3000);
        check(row_valid && row_idx == 2'd3, "R4 row 941 high-deviated accepted", int'(row_idx), 3);
        check(col_valid && col_idx == 2'd3, "R4 col 1633 low-deviated accepted", int'(col_idx), 3);

        // R4: 3.5% deviation rejected; R8 steer needs both
        set_tones(p770r, per_of(1336.0));
        wait_cyc(3000);
        check(!row_valid, "R4 row 770 +3.5% rejected", int'(row_valid), 0);
        check(col_valid && col_idx == 2'd1, "R3 col 1336 -> 1", int'(col_idx), 1);
        check(!early_steer, "R8 steer low with one group", int'(early_steer), 0);

        // R6: column change drops valid then reconfirms
        set_tones(per_of(852.0), per_of(1336.0));
        wait_cyc(3000);
        set_tones(per_of(852.0), per_of(1477.0));
        wait_cyc(300);
        check(!col_valid, "R6 column change drops valid", int'(col_valid), 0);
        wait_cyc(2500);
        check(col_valid && col_idx == 2'd2, "R6 new column confirmed", int'(col_idx), 2);

        // R7/R11: column silence times out, index held
        set_tones(per_of(852.0), 0);
        wait_cyc(TIMEOUT + 300);
        check(!col_valid, "R7 silence drops col_valid", int'(col_valid), 0);
        check(col_idx == 2'd2, "R11 col_idx held after silence", int'(col_idx), 2);
        check(row_valid && row_idx == 2'd2, "R2 row 852 -> 2 unaffected", int'(row_idx), 2);

        // R9: inhibit blocks 1633, rows unaffected
        @(negedge clk) inhibit_top = 1'b1;
        set_tones(per_of(941.0), per_of(1633.0));
        wait_cyc(3000);
        check(!col_valid, "R9 1633 blocked under inhibit", int'(col_valid), 0);
        check(row_valid && row_idx == 2'd3, "R9 row unaffected by inhibit", int'(row_idx), 3);
        @(negedge clk) inhibit_top = 1'b0;
        wait_cyc(2000);
        check(col_valid && col_idx == 2'd3, "R3 col 1633 -> 3", int'(col_idx), 3);
        @(negedge clk) inhibit_top = 1'b1;
        @(negedge clk);
        check(!col_valid, "R9 inhibit drops reported 1633", int'(col_valid), 0);
        @(negedge clk) inhibit_top = 1'b0;

        // R10: power-down clears and holds off detection
        wait_cyc(2000);
        @(negedge clk) power_down = 1'b1;
        @(negedge clk);
        check(!row_valid && !col_valid && row_idx == 2'd0 && col_idx == 2'd0,
              "R10 power-down clears", int'({row_valid, col_valid, row_idx, col_idx}), 0);
        wait_cyc(1500);
        check(!row_valid && !col_valid, "R10 no detection in power-down",
              int'({row_valid, col_valid}), 0);
        @(negedge clk) power_down = 1'b0;
        wait_cyc(per_of(941.0) * 3 + per_of(941.0) / 2);
        check(!row_valid, "R12 re-arm after power-down", int'(row_valid), 0);
        wait_cyc(2000);
        check(row_valid && col_valid, "R10 detection resumes", int'({row_valid, col_valid}), 3);

        // R2/R3: full index sweep
        for (int k = 0; k < 4; k++) begin
            set_tones(per_of(real'(ROW_F[k])), per_of(real'(COL_F[k])));
            wait_cyc(3500);
            check(row_valid && int'(row_idx) == k, "R2 row index sweep", int'(row_idx), k);
            check(col_valid && int'(col_idx) == k, "R3 col index sweep", int'(col_idx), k);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule